// File: doc/BRIEF.md
# Phase Error Meter for a Motor Speed Lock

The block compares a slow reference pulse train with a once-per-revolution tach pulse from a motor and turns their phase difference into a number. An edge-triggered phase/frequency detector raises an UP flag on a reference rising edge and a DOWN flag on a tach rising edge. It drops both flags as soon as the second edge arrives. While exactly one flag is high, a counter advances on every clock cycle in which the fast count enable is asserted. The count therefore measures how long the first edge led the second, in enabled ticks. The enable is typically a strobe near 1.5 MHz, and the reference is typically around 20 Hz.

When the second edge arrives, the block captures the count together with a lead/lag flag and restarts the counter from zero. It offers the result on a valid/ready output. A result stays on the outputs, unchanged, until the host accepts it with ready. A completion that occurs while an earlier result is still waiting is discarded, so the host always reads the oldest unread measurement. The raw UP and DOWN flags are also brought out so they can be observed. Both pulse inputs are asynchronous and pass through synchronizer flops.

Top module: `phase_err_meter`

## Requirements
- R1: A rising edge on `ref_in` sets `up_o` and a rising edge on `tach_in` sets `dn_o`. Each flag appears 3 clock edges after the input change, counting 2 synchronizer flops and the flag register. `up_o` and `dn_o` are never high together.
- R2: Once the second input's rising edge is seen, both flags are low on the next cycle. Further rising edges of the input whose flag is already set are ignored and do not restart the measurement.
- R3: The counter advances only in cycles where exactly one of `up_o`/`dn_o` is high and `tick_en` is 1. With `tick_en` held at 0, the captured magnitude is 0.
- R4: With `tick_en` held at 1 and the two inputs rising D cycles apart, `err_mag` equals D. `err_valid` rises on the second clock edge after the edge at which the later input was first sampled by the synchronizer, as seen at the ports.
- R5: `err_lead` is 1 when the tach edge came first, meaning the motor leads. It is 0 when the reference came first or both edges were seen in the same cycle. Simultaneous edges give a magnitude of 0.
- R6: The counter saturates at 2^CNT_W-1 and never wraps. A longer pulse reports all ones.
- R7: While `err_valid` is 1 and `err_ready` is 0, `err_valid`, `err_mag` and `err_lead` hold their values. A transfer takes place in a cycle where both `err_valid` and `err_ready` are 1.
- R8: A completion that occurs while an unaccepted result is held is dropped. After the held result is taken, no further result appears until the next measurement.
- R9: After reset, `err_valid`, `up_o`, `dn_o`, `err_mag` and `err_lead` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Asynchronous reference pulse |
| tach_in | input | 1 | Asynchronous once-per-revolution tach pulse |
| tick_en | input | 1 | Count strobe for the error counter |
| err_valid | output | 1 | A measurement is offered |
| err_ready | input | 1 | Host accepts the offered measurement |
| err_mag | output | CNT_W | Phase error magnitude in enabled ticks |
| err_lead | output | 1 | 1 when the motor (tach) led the reference |
| up_o | output | 1 | Reference-first detector flag |
| dn_o | output | 1 | Tach-first detector flag |

## Verification
A detector state that sticks shows up at once: both flags go high together, or a flag stays high after the second edge. In either case the next result's magnitude or its latency of two edges is wrong. A counter that is not cleared, or that wraps, shows up as the wrong magnitude in the very next transfer. A wrong capture of the sign flips `err_lead` on the first tach-first measurement. A broken hold stage shows up during back-pressure: the held value changes, or the dropped measurement appears after the host accepts the held one.

// File: rtl/phase_err_pkg.sv
package phase_err_pkg;

  // Which input's rising edge has been seen first in the current measurement.
  typedef enum logic [1:0] {
    PH_IDLE      = 2'b00,
    PH_REF_FIRST = 2'b01,
    PH_TACH_FIRST = 2'b10
  } ph_state_e;

  localparam int unsigned DEF_CNT_W  = 16;
  localparam int unsigned DEF_SYNC_N = 2;

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  // The flop after the synchronizer chain holds the previous sample for edge detection.
  localparam int unsigned LEN = STAGES + 1;

  logic [LEN-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[LEN-2:0], din};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import phase_err_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rise_ref,
  input  logic rise_tach,
  output logic up,
  output logic dn,
  output logic done,
  output logic tach_led
);
  ph_state_e st_q, st_d;

  always_comb begin
    st_d     = st_q;
    done     = 1'b0;
    tach_led = 1'b0;
    unique case (st_q)
      PH_IDLE: begin
        if (rise_ref && rise_tach) done = 1'b1;
        else if (rise_ref)         st_d = PH_REF_FIRST;
        else if (rise_tach)        st_d = PH_TACH_FIRST;
      end
      PH_REF_FIRST: begin
        if (rise_tach) begin
          done = 1'b1;
          st_d = PH_IDLE;
        end
      end
      PH_TACH_FIRST: begin
        tach_led = 1'b1;
        if (rise_ref) begin
          done = 1'b1;
          st_d = PH_IDLE;
        end
      end
      default: st_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= PH_IDLE;
    else        st_q <= st_d;
  end

  assign up = (st_q == PH_REF_FIRST);
  assign dn = (st_q == PH_TACH_FIRST);

endmodule

// File: rtl/err_counter.sv
module err_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up,
  input  logic             dn,
  input  logic             tick_en,
  input  logic             done,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             adv;

  assign adv     = (up ^ dn) & tick_en;
  assign cnt_inc = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
  // The tick in the closing cycle still counts toward the captured value.
  assign cap_o   = adv ? cnt_inc : cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (done) cnt_q <= '0;
    else if (adv)  cnt_q <= cnt_inc;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/phase_err_meter.sv
module phase_err_meter
  import phase_err_pkg::*;
#(
  parameter int unsigned CNT_W  = DEF_CNT_W,
  parameter int unsigned SYNC_N = DEF_SYNC_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  input  logic             tach_in,
  input  logic             tick_en,
  output logic             err_valid,
  input  logic             err_ready,
  output logic [CNT_W-1:0] err_mag,
  output logic             err_lead,
  output logic             up_o,
  output logic             dn_o
);
  logic             rise_ref, rise_tach;
  logic             done, tach_led;
  logic [CNT_W-1:0] cnt_now, cap_val;
  logic             take;

  edge_sync #(.STAGES(SYNC_N)) u_sync_ref (
    .clk(clk), .rst_n(rst_n), .din(ref_in), .rise(rise_ref)
  );

  edge_sync #(.STAGES(SYNC_N)) u_sync_tach (
    .clk(clk), .rst_n(rst_n), .din(tach_in), .rise(rise_tach)
  );

  pfd_core u_pfd (
    .clk(clk), .rst_n(rst_n),
    .rise_ref(rise_ref), .rise_tach(rise_tach),
    .up(up_o), .dn(dn_o), .done(done), .tach_led(tach_led)
  );

  err_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .up(up_o), .dn(dn_o), .tick_en(tick_en), .done(done),
    .cnt_o(cnt_now), .cap_o(cap_val)
  );

  // A new result may load only when the output slot is empty or is being emptied.
  assign take = done && (!err_valid || err_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_valid <= 1'b0;
      err_mag   <= '0;
      err_lead  <= 1'b0;
    end else if (take) begin
      err_valid <= 1'b1;
      err_mag   <= cap_val;
      err_lead  <= tach_led;
    end else if (err_valid && err_ready) begin
      err_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/phase_err_meter_chk.sv
module phase_err_meter_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             up_o,
  input logic             dn_o,
  input logic             done,
  input logic [CNT_W-1:0] cnt,
  input logic             err_valid,
  input logic             err_ready,
  input logic [CNT_W-1:0] err_mag,
  input logic             err_lead
);
  localparam logic [CNT_W-1:0] ALL1 = '1;

  p_flags_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_o && dn_o));

  p_clear_on_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!up_o && !dn_o));

  p_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_o && !dn_o) |-> (cnt == '0));

  p_valid_after_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (!err_valid || err_ready)) |=> err_valid);

  p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt == ALL1) && !done) |=> (cnt == ALL1));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && !err_ready) |=> (err_valid && $stable(err_mag) && $stable(err_lead)));

endmodule

bind phase_err_meter phase_err_meter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .up_o(up_o), .dn_o(dn_o), .done(done),
  .cnt(cnt_now), .err_valid(err_valid), .err_ready(err_ready),
  .err_mag(err_mag), .err_lead(err_lead)
);

// File: tb/phase_err_meter_tb.sv
module phase_err_meter_tb;
  localparam int unsigned W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0, tach_in = 1'b0, tick_en = 1'b1, err_ready = 1'b1;
  logic err_valid, err_lead, up_o, dn_o;
  logic [W-1:0] err_mag;

  int checks = 0;
  int errors = 0;
  logic [W:0] exp_q[$];   // {lead, mag}
  logic [W:0] held;

  always #2 clk = ~clk;   // 250 MHz

  phase_err_meter #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .tach_in(tach_in),
    .tick_en(tick_en), .err_valid(err_valid), .err_ready(err_ready),
    .err_mag(err_mag), .err_lead(err_lead), .up_o(up_o), .dn_o(dn_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Driver: one measurement, second edge 'gap' cycles after the first.
  task automatic run_pair(input bit ref_first, input int gap, input int mag, input bit lead, input bit push);
    ref_in = 1'b0; tach_in = 1'b0;
    step(6);
    if (push) exp_q.push_back({lead, mag[W-1:0]});
    if (gap == 0) begin ref_in = 1'b1; tach_in = 1'b1; end
    else if (ref_first) ref_in = 1'b1;
    else tach_in = 1'b1;
    if (gap > 0) begin
      step(gap);
      ref_in = 1'b1; tach_in = 1'b1;
    end
    step(6);
    ref_in = 1'b0; tach_in = 1'b0;
    step(4);
  endtask

  // Monitor: compare every transfer against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && err_valid && err_ready) begin
      logic [W:0] e;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R8 unexpected result actual=%0d expected=none", err_mag);
      end else begin
        e = exp_q.pop_front();
        if ({err_lead, err_mag} !== e) begin
          errors++;
          $display("FAIL R3/R4/R5/R6 result actual=lead%0d mag%0d expected=lead%0d mag%0d",
                   err_lead, err_mag, e[W], e[W-1:0]);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(4);
    // R9 reset state
    chk("R9 valid", err_valid, 0);
    chk("R9 flags", {up_o, dn_o}, 0);
    chk("R9 mag", err_mag, 0);
    rst_n = 1'b1;
    step(3);

    // R1 flag timing: ref raised now, up_o visible after the third edge
    ref_in = 1'b1;
    step(2);
    chk("R1 up early", up_o, 0);
    step(1);
    chk("R1 up set", up_o, 1);
    chk("R1 dn low", dn_o, 0);
    // R4 latency: tach raised 10 cycles after ref
    step(7);
    exp_q.push_back({1'b0, 8'd10});
    tach_in = 1'b1;
    step(2);
    chk("R4 valid not yet", err_valid, 0);
    step(1);
    chk("R4 valid", err_valid, 1);
    chk("R2 flags cleared", {up_o, dn_o}, 0);
    step(4);
    ref_in = 1'b0; tach_in = 1'b0;
    step(4);

    run_pair(1'b0, 7, 7, 1'b1, 1'b1);      // R5 tach first: motor leads
    run_pair(1'b1, 23, 23, 1'b0, 1'b1);    // R4 ref first, other gap
    run_pair(1'b1, 0, 0, 1'b0, 1'b1);      // R5 simultaneous edges

    tick_en = 1'b0;                        // R3 gating
    run_pair(1'b1, 12, 0, 1'b0, 1'b1);
    tick_en = 1'b1;

    run_pair(1'b1, 300, 255, 1'b0, 1'b1);  // R6 saturation

    // R2 repeated ref edge while UP set is ignored; tach 15 after first ref
    exp_q.push_back({1'b0, 8'd15});
    ref_in = 1'b1;
    step(4); ref_in = 1'b0;
    step(4); ref_in = 1'b1;
    step(7); tach_in = 1'b1;
    step(6); ref_in = 1'b0; tach_in = 1'b0;
    step(4);

    // R7/R8 back-pressure: A is held, B is dropped
    err_ready = 1'b0;
    run_pair(1'b0, 9, 9, 1'b1, 1'b1);
    held = {err_lead, err_mag};
    chk("R7 held valid", err_valid, 1);
    run_pair(1'b1, 20, 20, 1'b0, 1'b0);
    chk("R7 held stable", {err_lead, err_mag}, held);
    err_ready = 1'b1;
    step(10);
    chk("R8 dropped result absent", err_valid, 0);
    chk("R8 scoreboard drained", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule